// File: doc/BRIEF.md
# Multi-Mode Load Address Generator

This unit turns a load request into one or two memory reads and a register update. A request names an addressing mode, a base register, an index register, a destination register and an immediate. In the cycle it is accepted, the unit reads both registers and forms the effective address. It issues the first read to a synchronous memory in that same cycle. Data returns from the memory one cycle after each read request.

Most modes need a single read. Memory-indirect mode reads a pointer first and then loads from the pointer. Auto-increment and auto-decrement modes load from the base register's current value. In the cycle of acceptance they write the stepped value back to the base register.

The loaded word is returned on a response strobe and is written to the destination register through the single register-file write port. Requests use a valid/ready handshake. Ready is high only while the unit is idle.

Top module: `ldag_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req`, `rsp_valid` and `rf_we` are 0.
- R2: Mode codes 0 (absolute) and 7 (reserved) use `req_imm` as the read address.
- R3: Mode 1 (register indirect) uses the base register value as the read address.
- R4: Mode 2 (displaced) uses the base register value plus `req_imm` as the read address.
- R5: Mode 3 (indexed) uses the base register value plus the index register value as the read address.
- R6: Mode 4 (memory indirect) first reads at the base register value. One cycle after acceptance it issues a second read whose address is the word just returned. The response comes two cycles after acceptance.
- R7: Mode 5 (auto-increment) reads at the base register's old value. In the cycle of acceptance it writes old value + STEP (default 4) to the base register.
- R8: Mode 6 (auto-decrement) reads at the base register's old value. In the cycle of acceptance it writes old value − STEP to the base register.
- R9: In modes 5 and 6 with destination equal to base, no stepped value is written, and the register ends up holding the loaded word.
- R10: For single-read modes, `rsp_valid` is 1 exactly one cycle after acceptance. In that cycle `rsp_data` equals the returned word, and the same word is written to the destination register.
- R11: `req_ready` is 0 from the cycle after acceptance through the response cycle. A request held valid during that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle, request taken when valid |
| req_mode | input | 3 | Addressing mode code |
| req_base | input | RW | Base register number |
| req_index | input | RW | Index register number |
| req_dst | input | RW | Destination register number |
| req_imm | input | AW | Immediate / offset |
| rf_ra_addr | output | RW | Register read port A address (base) |
| rf_ra_data | input | AW | Register read port A data, same cycle |
| rf_rb_addr | output | RW | Register read port B address (index) |
| rf_rb_data | input | AW | Register read port B data, same cycle |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | RW | Register write address |
| rf_wdata | output | AW | Register write data |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read byte address |
| mem_rdata | input | AW | Memory read data, one cycle after strobe |
| rsp_valid | output | 1 | Loaded word available |
| rsp_data | output | AW | Loaded word |

## Verification
The assertions take three things for granted. The register file answers both read ports combinationally in the cycle of acceptance. The memory returns each read in the very next cycle. The mode code is stable while a request is valid. The bench models the register file as a combinational array and the memory as a registered lookup, which meets the first two. It drives request fields only at falling edges and holds them steady until the next falling edge, which meets the third.

// File: rtl/ldag_pkg.sv
package ldag_pkg;
  typedef enum logic [2:0] {
    M_ABS  = 3'd0,
    M_REG  = 3'd1,
    M_DISP = 3'd2,
    M_IDX  = 3'd3,
    M_MIND = 3'd4,
    M_AINC = 3'd5,
    M_ADEC = 3'd6,
    M_RSVD = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_FIRST  = 2'd1,
    S_SECOND = 2'd2
  } seq_e;
endpackage

// File: rtl/ldag_agen.sv
module ldag_agen
  import ldag_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  mode_e           mode,
  input  logic [AW-1:0]   base_val,
  input  logic [AW-1:0]   index_val,
  input  logic [AW-1:0]   imm,
  output logic [AW-1:0]   ea,
  output logic [AW-1:0]   wb_val,
  output logic            is_auto
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  function automatic logic [AW-1:0] f_ea(mode_e m, logic [AW-1:0] b,
                                         logic [AW-1:0] x, logic [AW-1:0] i);
    logic [AW-1:0] r;
    case (m)
      M_REG, M_MIND, M_AINC, M_ADEC: r = b;
      M_DISP:                        r = b + i;
      M_IDX:                         r = b + x;
      default:                       r = i;
    endcase
    return r;
  endfunction

  function automatic logic [AW-1:0] f_step(mode_e m, logic [AW-1:0] b);
    return (m == M_ADEC) ? (b - STEP_V) : (b + STEP_V);
  endfunction

  assign ea      = f_ea(mode, base_val, index_val, imm);
  assign wb_val  = f_step(mode, base_val);
  assign is_auto = (mode == M_AINC) || (mode == M_ADEC);
endmodule

// File: rtl/ldag_seq.sv
module ldag_seq
  import ldag_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          accept_indirect,
  input  logic [RW-1:0] accept_dst,
  output logic          idle,
  output logic          issue2,
  output logic          done,
  output logic [RW-1:0] dst_q
);
  seq_e st;
  logic ind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ind_q <= 1'b0;
      dst_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st    <= S_FIRST;
          ind_q <= accept_indirect;
          dst_q <= accept_dst;
        end
        S_FIRST: st <= ind_q ? S_SECOND : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign idle   = (st == S_IDLE);
  assign issue2 = (st == S_FIRST) && ind_q;
  assign done   = ((st == S_FIRST) && !ind_q) || (st == S_SECOND);

  // R6: the pointer read is always followed by the final result
  p_second_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue2 |=> done);
  // R11: the unit is idle again right after a result
  p_done_then_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);
endmodule

// File: rtl/ldag_top.sv
module ldag_top
  import ldag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NREG  = 32,
  parameter int STEP  = AW / 8,
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_mode,
  input  logic [RW-1:0] req_base,
  input  logic [RW-1:0] req_index,
  input  logic [RW-1:0] req_dst,
  input  logic [AW-1:0] req_imm,
  output logic [RW-1:0] rf_ra_addr,
  input  logic [AW-1:0] rf_ra_data,
  output logic [RW-1:0] rf_rb_addr,
  input  logic [AW-1:0] rf_rb_data,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [AW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_data
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  mode_e         req_m;
  logic [AW-1:0] ea, wb_val;
  logic          is_auto, accept, wb_fire, idle, issue2, done;
  logic [RW-1:0] dst_q;

  assign req_m      = mode_e'(req_mode);
  assign rf_ra_addr = req_base;
  assign rf_rb_addr = req_index;

  ldag_agen #(.AW(AW), .STEP(STEP)) u_agen (
    .mode(req_m), .base_val(rf_ra_data), .index_val(rf_rb_data), .imm(req_imm),
    .ea(ea), .wb_val(wb_val), .is_auto(is_auto)
  );

  ldag_seq #(.RW(RW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .accept_indirect(req_m == M_MIND), .accept_dst(req_dst),
    .idle(idle), .issue2(issue2), .done(done), .dst_q(dst_q)
  );

  assign req_ready = idle;
  assign accept    = req_valid && idle;
  // stepped base write is dropped when the loaded word targets the same register
  assign wb_fire   = accept && is_auto && (req_base != req_dst);

  assign mem_req   = accept || issue2;
  assign mem_addr  = issue2 ? mem_rdata : ea;

  assign rsp_valid = done;
  assign rsp_data  = mem_rdata;

  assign rf_we     = wb_fire || done;
  assign rf_waddr  = done ? dst_q : req_base;
  assign rf_wdata  = done ? mem_rdata : wb_val;

  // R11
  p_accept_drops_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R10
  p_single_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_m != M_MIND) |=> (rsp_valid && rf_we && rf_waddr == $past(req_dst)));
  // R6
  p_indirect_second_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_m == M_MIND) |=> (mem_req && !rsp_valid && !req_ready));
  // R6
  p_indirect_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_m == M_MIND) |-> ##2 rsp_valid);
  // R2
  p_absolute_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_m == M_ABS || req_m == M_RSVD)) |-> (mem_req && mem_addr == req_imm));
  // R7
  p_auto_inc_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_m == M_AINC && req_base != req_dst) |->
      (rf_we && rf_waddr == req_base && rf_wdata == rf_ra_data + STEP_V));
  // R8
  p_auto_dec_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_m == M_ADEC && req_base != req_dst) |->
      (rf_we && rf_waddr == req_base && rf_wdata == rf_ra_data - STEP_V));
  // R9
  p_same_reg_no_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_m == M_AINC || req_m == M_ADEC) && req_base == req_dst) |-> !rf_we);
  // R10
  p_rsp_writes_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rf_we && rf_wdata == rsp_data));
endmodule

// File: tb/ldag_top_test.sv
module ldag_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [4:0]  req_base = '0, req_index = '0, req_dst = '0;
  logic [31:0] req_imm = '0;
  logic [4:0]  rf_ra_addr, rf_rb_addr, rf_waddr;
  logic [31:0] rf_ra_data, rf_rb_data, rf_wdata;
  logic        rf_we, mem_req, rsp_valid;
  logic [31:0] mem_addr, mem_rdata, rsp_data;

  logic [31:0] rf  [32];
  logic [31:0] mem [256];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ldag_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_base(req_base), .req_index(req_index),
    .req_dst(req_dst), .req_imm(req_imm),
    .rf_ra_addr(rf_ra_addr), .rf_ra_data(rf_ra_data),
    .rf_rb_addr(rf_rb_addr), .rf_rb_data(rf_rb_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] rf_init(int i);
    case (i)
      2: return 32'h40;
      3: return 32'h0C;
      4: return 32'h28;
      default: return 32'(i) * 4;
    endcase
  endfunction

  assign rf_ra_data = rf[rf_ra_addr];
  assign rf_rb_data = rf[rf_rb_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= rf_init(i);
    end else if (rf_we) begin
      rf[rf_waddr] <= rf_wdata;
    end
    if (mem_req) mem_rdata <= mem[mem_addr[9:2]];
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 | (32'(i) << 4);
    mem[10] = 32'h0000_0080;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One load request per call; checks every cycle of its lifetime.
  task automatic run_load(input logic [2:0] mode, input logic [4:0] base, input logic [4:0] idx,
                          input logic [4:0] dst, input logic [31:0] imm, input string req);
    logic [31:0] b, x, ea, fin, word, stepped;
    bit ind, auto_m;
    b = rf[base]; x = rf[idx];
    case (mode)
      3'd1, 3'd4, 3'd5, 3'd6: ea = b;
      3'd2: ea = imm + b;
      3'd3: ea = x + b;
      default: ea = imm;
    endcase
    ind = (mode == 3'd4);
    auto_m = (mode == 3'd5) || (mode == 3'd6);
    stepped = (mode == 3'd6) ? b - 32'd4 : b + 32'd4;
    fin = ind ? mem[ea[9:2]] : ea;
    word = mem[fin[9:2]];

    @(negedge clk);
    req_valid = 1'b1; req_mode = mode; req_base = base; req_index = idx;
    req_dst = dst; req_imm = imm;
    #1;
    chk(req_ready, {req, " R11 ready before accept"}, 32'(req_ready), 32'd1);
    chk(mem_req && mem_addr == ea, {req, " first read address"}, mem_addr, ea);
    if (auto_m && base != dst)
      chk(rf_we && rf_waddr == base && rf_wdata == stepped, {req, " stepped base write"}, rf_wdata, stepped);
    if (auto_m && base == dst)
      chk(!rf_we, {req, " R9 no stepped write"}, 32'(rf_we), 32'd0);

    @(negedge clk);
    if (ind) begin
      #1;
      chk(mem_req && mem_addr == fin, {req, " R6 second read address"}, mem_addr, fin);
      chk(!rsp_valid && !req_ready, {req, " R11 busy between reads"}, 32'({rsp_valid, req_ready}), 32'd0);
      @(negedge clk);
    end else begin
      req_valid = 1'b0;
    end
    #1;
    chk(rsp_valid && rsp_data == word, {req, " R10 response word"}, rsp_data, word);
    chk(rf_we && rf_waddr == dst && rf_wdata == word, {req, " R10 destination write"}, rf_wdata, word);
    chk(!req_ready, {req, " R11 not ready in response cycle"}, 32'(req_ready), 32'd0);
    req_valid = 1'b0;

    @(negedge clk); #1;
    chk(!rsp_valid && !mem_req && req_ready, {req, " R11 held request not taken"},
        32'({rsp_valid, mem_req, req_ready}), 32'd1);
    chk(rf[dst] == word, {req, " destination holds word"}, rf[dst], word);
    if (auto_m && base != dst)
      chk(rf[base] == stepped, {req, " base register stepped"}, rf[base], stepped);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready && !mem_req && !rsp_valid && !rf_we, "R1 reset state",
        32'({req_ready, mem_req, rsp_valid, rf_we}), 32'b1000);

    run_load(3'd0, 5'd1, 5'd1, 5'd20, 32'h100, "R2 absolute");
    run_load(3'd7, 5'd1, 5'd1, 5'd21, 32'h200, "R2 reserved code");
    run_load(3'd1, 5'd2, 5'd1, 5'd22, 32'h0,   "R3 register indirect");
    run_load(3'd2, 5'd2, 5'd1, 5'd23, 32'h8,   "R4 displaced");
    run_load(3'd3, 5'd2, 5'd3, 5'd24, 32'h0,   "R5 indexed");
    run_load(3'd4, 5'd4, 5'd1, 5'd25, 32'h0,   "R6 memory indirect");
    run_load(3'd5, 5'd5, 5'd1, 5'd26, 32'h0,   "R7 auto increment");
    run_load(3'd5, 5'd5, 5'd1, 5'd27, 32'h0,   "R7 auto increment again");
    run_load(3'd6, 5'd7, 5'd1, 5'd28, 32'h0,   "R8 auto decrement");
    run_load(3'd5, 5'd9, 5'd1, 5'd9,  32'h0,   "R9 increment same register");
    run_load(3'd6, 5'd11, 5'd1, 5'd11, 32'h0,  "R9 decrement same register");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule